// File: doc/BRIEF.md
# Folding CRC-32 Stream Accumulator

This block consumes a message as a stream of 128-bit beats and reduces it to a single 128-bit folded remainder. The remainder is congruent to the message under the CRC-32 generator 0x04C11DB7, processed most significant bit first. Bit 127 of each beat is the earliest bit of that beat on the wire. A 32-bit starting CRC value is applied at the head of every message. A later stage that multiplies the remainder by x^32 and reduces it modulo the generator gets the CRC of the message. That final 32-bit reduction is not part of this block.

Internally the first four beats seed four 128-bit lanes. After that, each complete group of four beats advances every lane by 512 bit positions with carry-less multiplies by precomputed residues x^k mod P, and adds in the new beat. When the beat flagged as last arrives, the four lanes are merged into one accumulator. Any leftover beats that did not make up a full group are then folded in one at a time. The result is held on a valid/ready output. Messages must be a whole number of beats and at least four beats long. A shorter message is reported with an error flag.

Top module: `crcf_accum`

## Requirements
- R1: The 32-bit `crc_init` value is XORed into bits [127:96] of the first beat of a message. The other 96 bits of that beat, and every later beat, enter the fold unchanged.
- R2: After the first four beats, every complete later group of four beats updates lane j (j = position of the beat in its group, 0..3) as clmul(lane[127:64], 0x8833794C) XOR clmul(lane[63:0], 0xE6228B11) XOR beat.
- R3: When the message ends, the accumulator starts as lane 0. Lanes 1, 2 and 3 are then folded in, in that order. Each fold step is acc = clmul(acc[127:64], 0xC5B9CD4C) XOR clmul(acc[63:0], 0xE8A45605) XOR operand.
- R4: The one to three beats that follow the last complete group are folded into the merged accumulator in arrival order, using the R3 step.
- R5: For any valid message, (out_rem * x^32) mod P equals the MSB-first CRC-32 with polynomial 0x04C11DB7 and initial register `crc_init`, with no final inversion.
- R6: A message whose `in_last` beat is among its first three beats produces `out_valid` with `out_err` = 1 and `out_rem` = 0. Valid messages give `out_err` = 0.
- R7: Let t be the number of beats after the last complete group. `out_valid` rises 3 + t clock cycles after the cycle that accepts the last beat. For an error message it rises in the cycle right after that acceptance.
- R8: While `out_valid` is high and `out_ready` is low, `out_rem` and `out_err` stay unchanged and `in_ready` is low. The cycle after `out_ready` is accepted, the block is idle again.
- R9: After reset, and after each delivered result, `in_ready` is 1 and `out_valid` is 0. A new message does not depend on any earlier one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| crc_init | input | 32 | Starting CRC applied to the first beat of each message |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_data | input | 128 | Input beat, bit 127 earliest |
| in_last | input | 1 | Marks the final beat of a message |
| out_valid | output | 1 | Remainder available |
| out_ready | input | 1 | Consumer takes the remainder |
| out_rem | output | 128 | Folded 128-bit remainder |
| out_err | output | 1 | Message was shorter than four beats |

## Verification
The bench covers every tail count from zero to three, an exact four-beat message, and multi-group messages with idle gaps between beats. Each result is compared exactly against a behavioural fold model and also against a bit-serial CRC of the same data. A design that folded the leftover beats with the group constants, or merged the lanes out of order, would give a remainder that fails both comparisons. Short messages of one and three beats check that the error flag appears and that the next message is clean, which catches state left over from an aborted fill. The bench holds `out_ready` low for several cycles to catch a remainder that drifts or an input that is accepted while the result waits. It also counts the cycle in which `out_valid` rises, which catches an off-by-one in the merge step counter.

// File: rtl/crcf_pkg.sv
package crcf_pkg;
  localparam int BEAT_W  = 128;
  localparam int HALF_W  = BEAT_W / 2;
  localparam int CRC_W   = 32;
  localparam int LANES   = 4;
  localparam int STAGE_N = LANES - 1;
  localparam int SLOT_W  = $clog2(LANES);
  localparam int STEP_W  = $clog2(2 * LANES);
  localparam int PROD_W  = HALF_W + CRC_W;

  // residues x^k mod P for the group advance (k = 576, 512) and merge/tail (k = 192, 128)
  localparam logic [CRC_W-1:0] KG_HI = 32'h8833794C;
  localparam logic [CRC_W-1:0] KG_LO = 32'hE6228B11;
  localparam logic [CRC_W-1:0] KM_HI = 32'hC5B9CD4C;
  localparam logic [CRC_W-1:0] KM_LO = 32'hE8A45605;

  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic [1:0] {
    ST_FILL   = 2'd0,
    ST_GROUP  = 2'd1,
    ST_REDUCE = 2'd2,
    ST_HOLD   = 2'd3
  } state_e;

  function automatic logic [PROD_W-1:0] clmul_half(input logic [HALF_W-1:0] a,
                                                   input logic [CRC_W-1:0]  k);
    logic [PROD_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < CRC_W; i++) begin
      if (k[i]) acc ^= {{CRC_W{1'b0}}, a} << i;
    end
    return acc;
  endfunction
endpackage

// File: rtl/crcf_rst_sync.sv
module crcf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/crcf_fold.sv
module crcf_fold
  import crcf_pkg::*;
#(
  parameter logic [CRC_W-1:0] K_HI = KG_HI,
  parameter logic [CRC_W-1:0] K_LO = KG_LO
) (
  input  beat_t acc_i,
  input  beat_t add_i,
  output beat_t res_o
);
  logic [PROD_W-1:0] prod_hi;
  logic [PROD_W-1:0] prod_lo;

  assign prod_hi = clmul_half(acc_i[BEAT_W-1:HALF_W], K_HI);
  assign prod_lo = clmul_half(acc_i[HALF_W-1:0], K_LO);
  assign res_o   = {{(BEAT_W-PROD_W){1'b0}}, prod_hi ^ prod_lo} ^ add_i;
endmodule

// File: rtl/crcf_accum.sv
module crcf_accum
  import crcf_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [CRC_W-1:0]  crc_init,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BEAT_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BEAT_W-1:0] out_rem,
  output logic              out_err
);
  logic rst_n;

  crcf_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  // ---------------- state ----------------
  state_e              state_q, state_d;
  logic [SLOT_W-1:0]   slot_q, slot_d;
  logic [SLOT_W-1:0]   tail_q, tail_d;
  logic [STEP_W-1:0]   step_q, step_d;
  logic                err_q, err_d;
  beat_t               lane_q  [LANES];
  beat_t               lane_d  [LANES];
  logic [LANES-1:0]    lane_en;
  beat_t               stage_q [STAGE_N];
  beat_t               stage_d [STAGE_N];
  logic [STAGE_N-1:0]  stage_en;
  logic                ctl_en;

  logic  take;
  beat_t first_beat;
  beat_t group_res [LANES];
  beat_t merge_op;
  beat_t merge_res;
  logic  last_step;

  assign in_ready  = (state_q == ST_FILL) || (state_q == ST_GROUP);
  assign take      = in_valid && in_ready;
  assign out_valid = (state_q == ST_HOLD);
  assign out_err   = err_q;
  assign out_rem   = err_q ? '0 : lane_q[0];

  assign first_beat = in_data ^ {crc_init, {(BEAT_W-CRC_W){1'b0}}};

  // ---------------- group fold, one per lane ----------------
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    beat_t addend;
    if (j == LANES - 1) begin : g_direct
      assign addend = in_data;
    end else begin : g_staged
      assign addend = stage_q[j];
    end
    crcf_fold #(.K_HI(KG_HI), .K_LO(KG_LO)) u_fold (
      .acc_i (lane_q[j]),
      .add_i (addend),
      .res_o (group_res[j])
    );
  end

  // ---------------- merge / tail fold, shared ----------------
  always_comb begin
    if (step_q <= STEP_W'(STAGE_N)) merge_op = lane_q[step_q[SLOT_W-1:0]];
    else                            merge_op = stage_q[SLOT_W'(step_q - STEP_W'(LANES))];
  end

  crcf_fold #(.K_HI(KM_HI), .K_LO(KM_LO)) u_merge (
    .acc_i (lane_q[0]),
    .add_i (merge_op),
    .res_o (merge_res)
  );

  assign last_step = (step_q == STEP_W'(STAGE_N) + STEP_W'(tail_q));

  // ---------------- next state ----------------
  always_comb begin
    state_d  = state_q;
    slot_d   = slot_q;
    tail_d   = tail_q;
    step_d   = step_q;
    err_d    = err_q;
    ctl_en   = 1'b0;
    lane_en  = '0;
    stage_en = '0;
    for (int j = 0; j < LANES; j++)   lane_d[j]  = lane_q[j];
    for (int j = 0; j < STAGE_N; j++) stage_d[j] = in_data;

    unique case (state_q)
      ST_FILL: begin
        if (take) begin
          ctl_en                = 1'b1;
          lane_en[slot_q]       = 1'b1;
          lane_d[slot_q]        = (slot_q == '0) ? first_beat : in_data;
          if (in_last) begin
            if (slot_q == SLOT_W'(LANES - 1)) begin
              state_d = ST_REDUCE;
              tail_d  = '0;
              step_d  = STEP_W'(1);
            end else begin
              state_d = ST_HOLD;
              err_d   = 1'b1;
            end
          end else if (slot_q == SLOT_W'(LANES - 1)) begin
            state_d = ST_GROUP;
            slot_d  = '0;
          end else begin
            slot_d  = slot_q + 1'b1;
          end
        end
      end

      ST_GROUP: begin
        if (take) begin
          ctl_en = 1'b1;
          if (slot_q == SLOT_W'(LANES - 1)) begin
            lane_en = '1;
            for (int j = 0; j < LANES; j++) lane_d[j] = group_res[j];
            slot_d = '0;
            if (in_last) begin
              state_d = ST_REDUCE;
              tail_d  = '0;
              step_d  = STEP_W'(1);
            end
          end else begin
            stage_en[slot_q] = 1'b1;
            slot_d           = slot_q + 1'b1;
            if (in_last) begin
              state_d = ST_REDUCE;
              tail_d  = slot_q + 1'b1;
              step_d  = STEP_W'(1);
            end
          end
        end
      end

      ST_REDUCE: begin
        ctl_en     = 1'b1;
        lane_en[0] = 1'b1;
        lane_d[0]  = merge_res;
        step_d     = step_q + 1'b1;
        if (last_step) state_d = ST_HOLD;
      end

      ST_HOLD: begin
        if (out_ready) begin
          ctl_en  = 1'b1;
          lane_en = '1;
          for (int j = 0; j < LANES; j++) lane_d[j] = '0;
          state_d = ST_FILL;
          slot_d  = '0;
          err_d   = 1'b0;
        end
      end

      default: begin
        ctl_en  = 1'b1;
        state_d = ST_FILL;
      end
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FILL;
      slot_q  <= '0;
      tail_q  <= '0;
      step_q  <= '0;
      err_q   <= 1'b0;
    end else if (ctl_en) begin
      state_q <= state_d;
      slot_q  <= slot_d;
      tail_q  <= tail_d;
      step_q  <= step_d;
      err_q   <= err_d;
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lane_q[j] <= '0;
      else if (lane_en[j]) lane_q[j] <= lane_d[j];
    end
  end

  for (genvar j = 0; j < STAGE_N; j++) begin : g_stage_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           stage_q[j] <= '0;
      else if (stage_en[j]) stage_q[j] <= stage_d[j];
    end
  end

  // ---------------- assertions ----------------
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rem) && $stable(out_err)));

  // R8
  no_take_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R6
  err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid);

  // R6
  short_msg_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && take && in_last && slot_q != SLOT_W'(LANES - 1))
      |=> (out_valid && out_err));

  // R7
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REDUCE) |-> (step_q >= STEP_W'(1) &&
                                step_q <= STEP_W'(STAGE_N) + STEP_W'(tail_q)));

  // R9
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid && !out_err));
endmodule

// File: tb/crcf_accum_tb.sv
`timescale 1ns/1ps
module crcf_accum_tb_top;
  localparam logic [31:0] POLY = 32'h04C11DB7;

  logic         clk = 1'b0;
  logic         arst_n = 1'b0;
  logic [31:0]  crc_init = '1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic         in_last = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_rem;
  logic         out_err;

  int checks = 0;
  int errors = 0;

  logic [127:0] msg [16];
  logic [31:0]  k576, k512, k192, k128;

  always #2 clk = ~clk;

  crcf_accum dut_i (
    .clk(clk), .arst_n(arst_n), .crc_init(crc_init),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_rem(out_rem), .out_err(out_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] xk_mod(input int k);
    logic [31:0] r;
    logic        msb;
    r = 32'd1;
    for (int i = 0; i < k; i++) begin
      msb = r[31];
      r   = {r[30:0], 1'b0};
      if (msb) r ^= POLY;
    end
    return r;
  endfunction

  function automatic logic [127:0] bfold(input logic [127:0] a, input logic [31:0] kh,
                                         input logic [31:0] kl);
    logic [127:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) begin
      if (kh[i]) r ^= {64'd0, a[127:64]} << i;
      if (kl[i]) r ^= {64'd0, a[63:0]} << i;
    end
    return r;
  endfunction

  function automatic logic [127:0] model_rem(input int n, input logic [31:0] init);
    logic [127:0] ln [4];
    logic [127:0] acc;
    int g;
    for (int j = 0; j < 4; j++) ln[j] = msg[j];
    ln[0] ^= {init, 96'd0};
    g = n / 4;
    for (int grp = 1; grp < g; grp++)
      for (int j = 0; j < 4; j++) ln[j] = bfold(ln[j], k576, k512) ^ msg[4*grp + j];
    acc = ln[0];
    for (int j = 1; j < 4; j++) acc = bfold(acc, k192, k128) ^ ln[j];
    for (int i = 4*g; i < n; i++) acc = bfold(acc, k192, k128) ^ msg[i];
    return acc;
  endfunction

  function automatic logic [31:0] serial_crc(input int n, input logic [31:0] init);
    logic [31:0] c;
    logic        fb;
    c = init;
    for (int i = 0; i < n; i++)
      for (int b = 127; b >= 0; b--) begin
        fb = c[31] ^ msg[i][b];
        c  = {c[30:0], 1'b0};
        if (fb) c ^= POLY;
      end
    return c;
  endfunction

  function automatic logic [31:0] rem_to_crc(input logic [127:0] r);
    logic [159:0] v;
    v = {r, 32'd0};
    for (int i = 159; i >= 32; i--)
      if (v[i]) v ^= {127'd0, 1'b1, POLY} << (i - 32);
    return v[31:0];
  endfunction

  task automatic run_msg(input int n, input logic [31:0] init, input int gap,
                         input int hold, input string req, input bit fresh);
    logic [127:0] exp_rem;
    logic [127:0] held;
    bit           exp_err;
    int           lat;
    if (fresh) for (int i = 0; i < 16; i++) msg[i] = {$urandom, $urandom, $urandom, $urandom};
    exp_err = (n < 4);
    exp_rem = exp_err ? '0 : model_rem(n, init);
    lat     = exp_err ? 0 : 3 + (n % 4);
    crc_init = init;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) for (int k = 0; k < gap; k++) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = msg[i];
      in_last  = (i == n - 1);
      chk(in_ready == 1'b1, "R9", "in_ready during input", {127'd0, in_ready}, 128'd1);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    for (int c = 0; c <= lat; c++) begin
      chk(out_valid == (c == lat), "R7", $sformatf("out_valid at cycle %0d", c),
          {127'd0, out_valid}, {127'd0, c == lat});
      if (c < lat) @(negedge clk);
    end
    chk(out_rem == exp_rem, req, "remainder", out_rem, exp_rem);
    chk(out_err == exp_err, "R6", "error flag", {127'd0, out_err}, {127'd0, exp_err});
    if (!exp_err)
      chk(rem_to_crc(out_rem) == serial_crc(n, init), "R5", "crc congruence",
          {96'd0, rem_to_crc(out_rem)}, {96'd0, serial_crc(n, init)});
    held = out_rem;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(out_valid && !in_ready && out_rem == held, "R8", "held result",
          out_rem, held);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R9", "idle after delivery",
        {126'd0, out_valid, in_ready}, 128'd1);
  endtask

  initial begin
    k576 = xk_mod(576);
    k512 = xk_mod(512);
    k192 = xk_mod(192);
    k128 = xk_mod(128);
    repeat (4) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_ready && !out_valid, "R9", "reset state", {126'd0, in_ready, out_valid}, 128'd2);

    run_msg(4,  32'hFFFFFFFF, 0, 0, "R3", 1'b1);   // pure merge
    run_msg(8,  32'hFFFFFFFF, 0, 0, "R2", 1'b1);   // one group advance
    run_msg(5,  32'hFFFFFFFF, 0, 0, "R4", 1'b1);   // one tail beat
    run_msg(6,  32'hFFFFFFFF, 1, 0, "R4", 1'b1);   // two tail beats, gaps
    run_msg(7,  32'hFFFFFFFF, 0, 0, "R4", 1'b1);   // three tail beats
    run_msg(12, 32'h12345678, 2, 0, "R2", 1'b1);   // two group advances
    run_msg(15, 32'hFFFFFFFF, 0, 3, "R4", 1'b1);   // groups plus tail, held output
    run_msg(9,  32'h00000000, 0, 0, "R1", 1'b1);   // zero init
    run_msg(9,  32'hA5A5F00F, 0, 0, "R1", 1'b0);   // same data, other init
    run_msg(1,  32'hFFFFFFFF, 0, 2, "R6", 1'b1);   // short message
    run_msg(3,  32'hFFFFFFFF, 0, 0, "R6", 1'b1);   // short message
    run_msg(4,  32'hFFFFFFFF, 0, 5, "R9", 1'b1);   // clean after error, held

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule